// File: doc/BRIEF.md
# Row-Hit-First Rank-Aware Request Picker

This block picks the next memory request to issue for one transfer direction (all reads or all writes) out of a set of per-priority request queues. Each queue slot gives its target rank, bank and row. Slot 0 holds the oldest request and higher slot numbers hold younger ones. Per-bank tables give the open-row flag, the open-row value and the earliest time a column command may issue. The picker also takes a per-rank refresh-idle flag and a per-rank mask of the banks that are soonest able to take an activate.

Queues are searched from the highest priority index down. Within a queue the rule is one of two: plain oldest-first, or a row-hit-first rule that prefers accesses which can reuse an open row. A request whose rank is refreshing is never eligible. When the read/write direction has just turned, the block adds a turnaround margin to the column-readiness test.

A request enters on a valid/ready strobe. The decision is held in a result register that is valid one cycle later. The result stays stable until the consumer takes it. While a result is pending and not taken, new strobes are refused. The result register frees in the same cycle it is taken, so a new strobe in that cycle is accepted.

Top module: `rowhit_req_picker`

## Requirements
- R1: The result names the highest-index priority queue that holds an eligible request. Lower queues are not considered once a higher one yields a pick.
- R2: A request is eligible only if its slot valid bit is set and the rank_idle bit of its rank is 1. If no queue yields a pick, res_found is 0.
- R3: If a queue holds exactly one valid request, that request is picked when its rank is idle and rejected otherwise. This holds under either policy, whatever its row or bank state.
- R4: With policy = 0 (oldest-first), the lowest-numbered eligible slot of the queue is picked, and row state is ignored.
- R5: With policy = 1 (row-hit-first), a row hit (bank open flag 1 and open row equal to the request row) is seamless when its bank column time is at or below now_time plus the turnaround margin. The first seamless hit is picked, even if an older hit that is not seamless exists.
- R6: With policy = 1 and no seamless hit, the oldest non-seamless row hit is picked in preference to any non-hit request.
- R7: With policy = 1 and no row hit, the oldest eligible request whose bank bit is set in early_bank (bit index rank*NBANK+bank) is picked. If there is none, the queue yields nothing and the search moves to the next lower queue.
- R8: The turnaround margin depends on the direction inputs. It is 0 when dir_switch = 0. It is t_rank_sw on a switch to reads (new_dir = 0). It is the smaller of t_rd2wr and t_rank_sw on a switch to writes (new_dir = 1).
- R9: A strobe is accepted when req_valid and req_ready are both 1, where req_ready = !res_valid || res_ready. The result is valid on the following cycle. While res_valid = 1 and res_ready = 0, res_found, res_prio and res_idx do not change.
- R10: After reset, res_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request a pick on the present inputs |
| req_ready | output | 1 | A pick request is accepted this cycle |
| policy | input | 1 | 0 oldest-first, 1 row-hit-first |
| ent_valid | input | NPRIO*NENT | Slot valid, bit q*NENT+e |
| ent_rank | input | NPRIO*NENT*RW | Slot rank fields |
| ent_bank | input | NPRIO*NENT*BW | Slot bank fields |
| ent_row | input | NPRIO*NENT*ROW_W | Slot row fields |
| bank_open | input | NRANK*NBANK | Bank has an open row, bit rank*NBANK+bank |
| bank_row | input | NRANK*NBANK*ROW_W | Open row per bank |
| bank_col_at | input | NRANK*NBANK*TIME_W | Earliest column time per bank |
| rank_idle | input | NRANK | Rank is refresh-idle |
| early_bank | input | NRANK*NBANK | Banks soonest able to activate |
| now_time | input | TIME_W | Present time |
| dir_switch | input | 1 | Direction has just turned |
| new_dir | input | 1 | New direction: 0 reads, 1 writes |
| t_rank_sw | input | TIME_W | Rank-to-rank switch delay |
| t_rd2wr | input | TIME_W | Read-to-write delay |
| res_valid | output | 1 | Result holds a decision |
| res_ready | input | 1 | Consumer takes the result |
| res_found | output | 1 | A request was picked |
| res_prio | output | PW | Picked queue index |
| res_idx | output | IW | Picked slot index |

## Verification
Two things can land on the same clock edge: holding a result that is not yet taken, and a new pick strobe. The bench raises req_valid with fresh queue contents while res_ready is low. It then confirms that req_ready is 0 and that the old decision is unchanged. Next it raises res_ready with the strobe still high. In that one cycle the old result is released and the new pick is accepted, and the bench confirms the new decision appears on the next cycle. A second overlap is the turnaround margin deciding between a seamless hit and a prepared hit. The same queue is evaluated under each direction setting, and the picked slot shows which margin was applied.

// File: rtl/picker_pkg.sv
package picker_pkg;
  typedef enum logic {POL_OLDEST = 1'b0, POL_ROWHIT = 1'b1} pick_pol_e;

  function automatic int wbits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pick_queue_sel.sv
module pick_queue_sel
  import picker_pkg::*;
#(
  parameter int NENT   = 4,
  parameter int NRANK  = 2,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int TIME_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          policy,
  input  logic [NENT-1:0]               ent_valid,
  input  logic [NENT*wbits(NRANK)-1:0]  ent_rank,
  input  logic [NENT*wbits(NBANK)-1:0]  ent_bank,
  input  logic [NENT*ROW_W-1:0]         ent_row,
  input  logic [NRANK*NBANK-1:0]        bank_open,
  input  logic [NRANK*NBANK*ROW_W-1:0]  bank_row,
  input  logic [NRANK*NBANK*TIME_W-1:0] bank_col_at,
  input  logic [NRANK-1:0]              rank_idle,
  input  logic [NRANK*NBANK-1:0]        early_bank,
  input  logic [TIME_W:0]               min_col,
  output logic                          q_found,
  output logic [wbits(NENT)-1:0]        q_idx
);
  localparam int RW = wbits(NRANK);
  localparam int BW = wbits(NBANK);
  localparam int IW = wbits(NENT);
  localparam logic [NENT-1:0] ONE = NENT'(1);

  logic [NENT-1:0] elig;
  logic            seam_f, prep_f, erl_f, old_f;
  logic [IW-1:0]   seam_i, prep_i, erl_i, old_i;
  int              nval;

  always_comb begin
    elig   = '0;
    seam_f = 1'b0; prep_f = 1'b0; erl_f = 1'b0; old_f = 1'b0;
    seam_i = '0;   prep_i = '0;   erl_i = '0;   old_i = '0;
    nval   = $countones(ent_valid);
    for (int i = 0; i < NENT; i++) begin
      logic [RW-1:0] rk;
      logic [BW-1:0] bk;
      int            tix;
      logic          el, hit, seam;
      rk   = ent_rank[i*RW +: RW];
      bk   = ent_bank[i*BW +: BW];
      tix  = int'(rk) * NBANK + int'(bk);
      el   = ent_valid[i] && (int'(rk) < NRANK) && (tix < NRANK*NBANK);
      if (el) el = rank_idle[rk];
      elig[i] = el;
      hit  = 1'b0;
      seam = 1'b0;
      if (el) begin
        hit  = bank_open[tix] &&
               (bank_row[tix*ROW_W +: ROW_W] == ent_row[i*ROW_W +: ROW_W]);
        seam = hit && ({1'b0, bank_col_at[tix*TIME_W +: TIME_W]} <= min_col);
      end
      if (el && !old_f) begin
        old_f = 1'b1; old_i = IW'(i);
      end
      if (seam && !seam_f) begin
        seam_f = 1'b1; seam_i = IW'(i);
      end else if (hit && !seam && !prep_f) begin
        prep_f = 1'b1; prep_i = IW'(i);
      end else if (el && !hit && early_bank[tix] && !erl_f) begin
        erl_f = 1'b1; erl_i = IW'(i);
      end
    end
  end

  always_comb begin
    if (nval == 1 || policy == POL_OLDEST) begin
      q_found = old_f;  q_idx = old_i;
    end else if (seam_f) begin
      q_found = 1'b1;   q_idx = seam_i;
    end else if (prep_f) begin
      q_found = 1'b1;   q_idx = prep_i;
    end else begin
      q_found = erl_f;  q_idx = erl_i;
    end
  end

  // R2: a pick always targets a valid slot on an idle rank
  a_r2_idle_rank: assert property (@(posedge clk) disable iff (!rst_n)
    q_found |-> (ent_valid[q_idx] && rank_idle[ent_rank[q_idx*RW +: RW]]));

  // R4: oldest-first never skips an older eligible slot
  a_r4_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_OLDEST && q_found) |->
      ((elig & ((ONE << q_idx) - ONE)) == '0));

  // R3: a lone eligible request is always taken
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ent_valid) == 1 && (ent_valid & elig) != '0) |-> q_found);
endmodule

// File: rtl/pick_prio_scan.sv
module pick_prio_scan
  import picker_pkg::*;
#(
  parameter int NPRIO = 4,
  parameter int NENT  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPRIO-1:0]             q_found,
  input  logic [NPRIO*wbits(NENT)-1:0] q_idx,
  output logic                         found,
  output logic [wbits(NPRIO)-1:0]      prio,
  output logic [wbits(NENT)-1:0]       idx
);
  localparam int IW = wbits(NENT);
  localparam int PW = wbits(NPRIO);

  always_comb begin
    found = 1'b0;
    prio  = '0;
    idx   = '0;
    for (int p = 0; p < NPRIO; p++) begin
      if (q_found[p]) begin
        found = 1'b1;
        prio  = PW'(p);
        idx   = q_idx[p*IW +: IW];
      end
    end
  end

  // R1: nothing above the chosen queue had a candidate
  a_r1_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((q_found >> prio) == NPRIO'(1)));

  // R2: no candidate anywhere means no pick
  a_r2_none: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (q_found == '0));
endmodule

// File: rtl/rowhit_req_picker.sv
module rowhit_req_picker
  import picker_pkg::*;
#(
  parameter int NPRIO  = 4,
  parameter int NENT   = 4,
  parameter int NRANK  = 2,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int TIME_W = 12
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  output logic                                    req_ready,
  input  logic                                    policy,
  input  logic [NPRIO*NENT-1:0]                   ent_valid,
  input  logic [NPRIO*NENT*wbits(NRANK)-1:0]      ent_rank,
  input  logic [NPRIO*NENT*wbits(NBANK)-1:0]      ent_bank,
  input  logic [NPRIO*NENT*ROW_W-1:0]             ent_row,
  input  logic [NRANK*NBANK-1:0]                  bank_open,
  input  logic [NRANK*NBANK*ROW_W-1:0]            bank_row,
  input  logic [NRANK*NBANK*TIME_W-1:0]           bank_col_at,
  input  logic [NRANK-1:0]                        rank_idle,
  input  logic [NRANK*NBANK-1:0]                  early_bank,
  input  logic [TIME_W-1:0]                       now_time,
  input  logic                                    dir_switch,
  input  logic                                    new_dir,
  input  logic [TIME_W-1:0]                       t_rank_sw,
  input  logic [TIME_W-1:0]                       t_rd2wr,
  output logic                                    res_valid,
  input  logic                                    res_ready,
  output logic                                    res_found,
  output logic [wbits(NPRIO)-1:0]                 res_prio,
  output logic [wbits(NENT)-1:0]                  res_idx
);
  localparam int RW = wbits(NRANK);
  localparam int BW = wbits(NBANK);
  localparam int IW = wbits(NENT);
  localparam int PW = wbits(NPRIO);

  logic [TIME_W-1:0]   margin;
  logic [TIME_W:0]     min_col;
  logic [NPRIO-1:0]    q_found;
  logic [NPRIO*IW-1:0] q_idx;
  logic                pick_found;
  logic [PW-1:0]       pick_prio;
  logic [IW-1:0]       pick_idx;
  logic                accept;

  always_comb begin
    if (!dir_switch)  margin = '0;
    else if (new_dir) margin = (t_rd2wr < t_rank_sw) ? t_rd2wr : t_rank_sw;
    else              margin = t_rank_sw;
    min_col = {1'b0, now_time} + {1'b0, margin};
  end

  for (genvar q = 0; q < NPRIO; q++) begin : g_queue
    localparam int E0 = q * NENT;
    pick_queue_sel #(
      .NENT(NENT), .NRANK(NRANK), .NBANK(NBANK),
      .ROW_W(ROW_W), .TIME_W(TIME_W)
    ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .policy     (policy),
      .ent_valid  (ent_valid[E0 +: NENT]),
      .ent_rank   (ent_rank[E0*RW +: NENT*RW]),
      .ent_bank   (ent_bank[E0*BW +: NENT*BW]),
      .ent_row    (ent_row[E0*ROW_W +: NENT*ROW_W]),
      .bank_open  (bank_open),
      .bank_row   (bank_row),
      .bank_col_at(bank_col_at),
      .rank_idle  (rank_idle),
      .early_bank (early_bank),
      .min_col    (min_col),
      .q_found    (q_found[q]),
      .q_idx      (q_idx[q*IW +: IW])
    );
  end

  pick_prio_scan #(.NPRIO(NPRIO), .NENT(NENT)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .q_found(q_found),
    .q_idx  (q_idx),
    .found  (pick_found),
    .prio   (pick_prio),
    .idx    (pick_idx)
  );

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_found <= 1'b0;
      res_prio  <= '0;
      res_idx   <= '0;
    end else begin
      if (accept) begin
        res_valid <= 1'b1;
        res_found <= pick_found;
        res_prio  <= pick_prio;
        res_idx   <= pick_idx;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R9: an accepted strobe yields a result on the next cycle
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  // R9: a result not yet taken stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_found) && $stable(res_prio) && $stable(res_idx)));

  // R9: no acceptance while a result is stalled
  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);
endmodule

// File: tb/tb_rowhit_req_picker.sv
module tb_rowhit_req_picker;
  localparam int NPRIO = 4, NENT = 4, NRANK = 2, NBANK = 4, ROW_W = 8, TIME_W = 12;
  localparam int RW = 1, BW = 2, IW = 2, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_ready, policy;
  logic [NPRIO*NENT-1:0]          ent_valid;
  logic [NPRIO*NENT*RW-1:0]       ent_rank;
  logic [NPRIO*NENT*BW-1:0]       ent_bank;
  logic [NPRIO*NENT*ROW_W-1:0]    ent_row;
  logic [NRANK*NBANK-1:0]         bank_open, early_bank;
  logic [NRANK*NBANK*ROW_W-1:0]   bank_row;
  logic [NRANK*NBANK*TIME_W-1:0]  bank_col_at;
  logic [NRANK-1:0]               rank_idle;
  logic [TIME_W-1:0]              now_time, t_rank_sw, t_rd2wr;
  logic dir_switch, new_dir, res_valid, res_ready, res_found;
  logic [PW-1:0] res_prio;
  logic [IW-1:0] res_idx;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rowhit_req_picker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .policy(policy), .ent_valid(ent_valid), .ent_rank(ent_rank),
    .ent_bank(ent_bank), .ent_row(ent_row), .bank_open(bank_open),
    .bank_row(bank_row), .bank_col_at(bank_col_at), .rank_idle(rank_idle),
    .early_bank(early_bank), .now_time(now_time), .dir_switch(dir_switch),
    .new_dir(new_dir), .t_rank_sw(t_rank_sw), .t_rd2wr(t_rd2wr),
    .res_valid(res_valid), .res_ready(res_ready), .res_found(res_found),
    .res_prio(res_prio), .res_idx(res_idx)
  );

  task automatic clr();
    ent_valid = '0; ent_rank = '0; ent_bank = '0; ent_row = '0;
    bank_open = '0; bank_row = '0; bank_col_at = '0; early_bank = '0;
    rank_idle = '1; now_time = 12'd100; dir_switch = 1'b0; new_dir = 1'b0;
    t_rank_sw = 12'd5; t_rd2wr = 12'd3; policy = 1'b0;
  endtask

  task automatic put(int q, int e, int r, int b, int row);
    int f = q * NENT + e;
    ent_valid[f] = 1'b1;
    ent_rank[f*RW +: RW] = RW'(r);
    ent_bank[f*BW +: BW] = BW'(b);
    ent_row[f*ROW_W +: ROW_W] = ROW_W'(row);
  endtask

  task automatic bank(int r, int b, bit open, int row, int col);
    int t = r * NBANK + b;
    bank_open[t] = open;
    bank_row[t*ROW_W +: ROW_W] = ROW_W'(row);
    bank_col_at[t*TIME_W +: TIME_W] = TIME_W'(col);
  endtask

  task automatic fire();
    @(negedge clk) req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk) req_valid = 1'b0;
  endtask

  task automatic expect_res(string tag, bit f, int p, int i);
    checks++;
    if (!res_valid || res_found != f || (f && (int'(res_prio) != p || int'(res_idx) != i))) begin
      errors++;
      $display("FAIL %s: got v=%0d f=%0d p=%0d i=%0d, expected v=1 f=%0d p=%0d i=%0d",
               tag, res_valid, res_found, res_prio, res_idx, f, p, i);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: got res_valid=%0d req_ready=%0d, expected 0 1", res_valid, req_ready);
    end
  endtask

  task automatic t_prio();
    clr(); put(1, 0, 0, 0, 1); put(3, 2, 1, 1, 2);
    fire(); expect_res("R1 highest queue", 1, 3, 2);
    rank_idle[1] = 1'b0;
    fire(); expect_res("R1 fall to lower queue", 1, 1, 0);
  endtask

  task automatic t_idle();
    clr(); put(0, 0, 1, 0, 1); put(0, 1, 1, 2, 1); put(2, 3, 1, 1, 4);
    rank_idle[1] = 1'b0;
    fire(); expect_res("R2 none oldest-first", 0, 0, 0);
    policy = 1'b1; early_bank = '1;
    fire(); expect_res("R2 none row-hit-first", 0, 0, 0);
  endtask

  task automatic t_single();
    clr(); policy = 1'b1; put(0, 2, 0, 3, 5);
    fire(); expect_res("R3 lone request taken", 1, 0, 2);
    rank_idle[0] = 1'b0;
    fire(); expect_res("R3 lone request busy rank", 0, 0, 0);
  endtask

  task automatic t_oldest();
    clr(); put(2, 0, 1, 0, 1); put(2, 1, 0, 1, 2); put(2, 2, 0, 2, 9);
    bank(0, 2, 1'b1, 9, 0); rank_idle[1] = 1'b0;
    fire(); expect_res("R4 oldest eligible", 1, 2, 1);
  endtask

  task automatic t_rowhit();
    clr(); policy = 1'b1;
    put(0, 0, 0, 0, 7); bank(0, 0, 1'b1, 7, 200);
    put(0, 1, 0, 1, 3); early_bank[0*NBANK+1] = 1'b1;
    put(0, 2, 0, 2, 9); bank(0, 2, 1'b1, 9, 50);
    fire(); expect_res("R5 seamless over prepared", 1, 0, 2);
    bank(0, 2, 1'b1, 9, 150);
    fire(); expect_res("R6 prepared over non-hit", 1, 0, 0);
    bank(0, 0, 1'b1, 8, 200); bank(0, 2, 1'b0, 9, 150);
    fire(); expect_res("R7 early bank non-hit", 1, 0, 1);
  endtask

  task automatic t_early();
    clr(); policy = 1'b1;
    put(1, 0, 0, 3, 1); put(1, 1, 1, 0, 2); early_bank[1*NBANK+0] = 1'b1;
    fire(); expect_res("R7 oldest in early mask", 1, 1, 1);
    put(3, 0, 0, 1, 4); put(3, 1, 1, 2, 5);
    fire(); expect_res("R7 queue without candidate skipped", 1, 1, 1);
  endtask

  task automatic t_margin();
    clr(); policy = 1'b1;
    put(0, 0, 0, 0, 7); bank(0, 0, 1'b1, 7, 200);
    put(0, 1, 0, 1, 4); bank(0, 1, 1'b1, 4, 104);
    fire(); expect_res("R8 no switch margin 0", 1, 0, 0);
    dir_switch = 1'b1; new_dir = 1'b0;
    fire(); expect_res("R8 switch to reads rank delay", 1, 0, 1);
    new_dir = 1'b1;
    fire(); expect_res("R8 switch to writes min delay 3", 1, 0, 0);
    t_rd2wr = 12'd6;
    fire(); expect_res("R8 switch to writes min delay 5", 1, 0, 1);
  endtask

  task automatic t_hold();
    clr(); put(2, 1, 0, 0, 1);
    @(negedge clk) res_ready = 1'b0;
    fire(); expect_res("R9 first result", 1, 2, 1);
    clr(); put(3, 3, 1, 0, 1);
    req_valid = 1'b1;
    checks++;
    if (req_ready !== 1'b0) begin
      errors++; $display("FAIL R9: req_ready=%0d while stalled, expected 0", req_ready);
    end
    @(posedge clk); @(negedge clk);
    expect_res("R9 held while stalled", 1, 2, 1);
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    expect_res("R9 release and accept together", 1, 3, 3);
  endtask

  initial begin
    req_valid = 1'b0; res_ready = 1'b1; clr();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_prio();
    t_idle();
    t_single();
    t_oldest();
    t_rowhit();
    t_early();
    t_margin();
    t_hold();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule